// File: doc/BRIEF.md
# RGMII Delay-Line Retune Sequencer

This block drives the retune of one port's receive and transmit clock delay lines. On a start pulse it captures a role flag, separate enables for the receive and transmit delay lines, and a phase in whole degrees. It converts the phase into a 5-bit delay code and issues two ordered 32-bit writes to the port's pad delay register through a valid/ready write channel.

The first write turns both delay lines off: both are bypassed and powered down. The second write brings back only the lines that were asked for. This power cycle lets an enabled line re-lock after the link partner has changed its clock frequency. The transport behind the write channel reports each acceptance with `wr_ready` and may flag it as failed with `wr_fail`.

A MAC role means no retune is needed, so the block signals a skip and writes nothing. An out-of-range phase is rejected before any write is issued. A failed transfer aborts the sequence.

Top module: `rdly_retune_seq`

## Requirements
- R1: The delay code is (phase*10 - 738)/9 with integer division, over the accepted phase range 74 to 101 degrees. So 74 gives 0, 80 gives 6, 90 gives 18 and 101 gives 30.
- R2: Each write word places fields as follows. The receive side has override in bit 15, delay code in bits 14:10, bypass in bit 9 and power-down in bit 8. The transmit side has override in bit 7, delay code in bits 6:2, bypass in bit 1 and power-down in bit 0. All other bits are zero.
- R3: The first write sets bypass and power-down on both sides. It carries the delay code on each enabled side and zero in the code field of each disabled side.
- R4: The second write keeps the same codes. It clears bypass and power-down on the enabled sides only; a disabled side stays bypassed and powered down.
- R5: Both override bits are zero in every write.
- R6: With `role_mac` high at start, no write is issued. `seq_skip` pulses for one cycle in the cycle after the start edge, even if the phase is out of range.
- R7: In a non-MAC role, a phase outside 74..101 causes `err_phase` to pulse for one cycle in the cycle after the start edge, and no write is issued.
- R8: The second write is presented only after the first has been accepted without failure. While `wr_valid` is high and `wr_ready` is low, `wr_data` holds its value.
- R9: If either write is accepted with `wr_fail` high, `err_bus` pulses in the following cycle and no further write is presented.
- R10: After the second write is accepted without failure, `seq_done` pulses in the following cycle and `wr_valid` is low.
- R11: A start pulse while the block is busy is ignored. The running sequence keeps the configuration it captured at its own start.
- R12: After reset, `wr_valid`, `wr_data`, `busy` and all outcome pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a retune; sampled only when idle |
| role_mac | input | 1 | High: MAC role, retune skipped |
| rx_dly_en | input | 1 | Apply a delay on the receive clock |
| tx_dly_en | input | 1 | Apply a delay on the transmit clock |
| phase_deg | input | 7 | Requested delay phase in whole degrees |
| wr_valid | output | 1 | Write request pending |
| wr_data | output | 32 | Pad delay register word; zero when idle |
| wr_ready | input | 1 | Transport accepts the current write |
| wr_fail | input | 1 | Accepted write failed (valid with wr_ready) |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle pulse: both writes accepted |
| seq_skip | output | 1 | One-cycle pulse: MAC role, nothing written |
| err_phase | output | 1 | One-cycle pulse: phase out of range |
| err_bus | output | 1 | One-cycle pulse: a write failed, sequence aborted |

## Verification
The assertions assume that the transport raises `wr_ready` only while `wr_valid` is high, and that it drives `wr_fail` only together with `wr_ready`. They also assume that every input is a clean level at each clock edge. The bench's write responder obeys these rules. It raises `wr_ready` only after it sees `wr_valid` at a falling edge, and only after a chosen latency of zero to three cycles. It asserts `wr_fail` solely in that acceptance cycle and clears both signals at the next falling edge. Start pulses are also driven mid-sequence with conflicting settings, so the bench observes the hold of the captured configuration at the ports.

// File: rtl/rdly_pkg.sv
// Shared definitions for the delay-line retune sequencer.
// Assumes a 32-bit pad delay word made of two 8-bit lane slices:
// transmit lane in bits 7:0, receive lane in bits 15:8.
package rdly_pkg;
    localparam int WORD_W   = 32;
    localparam int CODE_W   = 5;
    localparam int LANE_W   = 8;
    localparam int NUM_LANE = 2;
    localparam int LANE_TX  = 0;
    localparam int LANE_RX  = 1;

    // Positions inside one lane slice.
    localparam int SL_OVR   = 7;
    localparam int SL_CLSB  = 2;
    localparam int SL_BYP   = 1;
    localparam int SL_PD    = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OFF  = 2'd1,
        ST_ON   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
    } lane_cfg_t;
endpackage

// File: rtl/rdly_phase_code.sv
// Converts a phase in whole degrees to a delay-line code.
// code = (phase*SCALE - OFFSET) / STEP, valid for PH_MIN..PH_MAX.
// Assumes parameters keep the maximum code within CODE_W bits.
module rdly_phase_code #(
    parameter int PHASE_W = 7,
    parameter int CODE_W  = 5,
    parameter int PH_MIN  = 74,
    parameter int PH_MAX  = 101,
    parameter int SCALE   = 10,
    parameter int OFFSET  = 738,
    parameter int STEP    = 9
) (
    input  logic [PHASE_W-1:0] phase,
    output logic               in_range,
    output logic [CODE_W-1:0]  code
);
    localparam int PROD_W = PHASE_W + $clog2(SCALE + 1);

    logic [PROD_W-1:0] scaled;
    logic [PROD_W-1:0] shifted;
    logic [PROD_W-1:0] quot;

    // Range check and fixed-point conversion of the phase.
    always_comb begin
        in_range = (int'(phase) >= PH_MIN) && (int'(phase) <= PH_MAX);
        scaled   = PROD_W'(phase) * PROD_W'(SCALE);
        shifted  = in_range ? (scaled - PROD_W'(OFFSET)) : '0;
        quot     = shifted / PROD_W'(STEP);
        code     = quot[CODE_W-1:0];
    end
endmodule

// File: rtl/rdly_word_pack.sv
// Packs the two lane configurations into the pad delay word.
// Stage OFF bypasses and powers down every lane; stage ON releases
// only enabled lanes. Disabled lanes carry a zero code. Override stays 0.
module rdly_word_pack
    import rdly_pkg::*;
(
    input  lane_cfg_t          lane [NUM_LANE],
    input  logic               stage_on,
    output logic [WORD_W-1:0]  word
);
    localparam int USED_W = NUM_LANE * LANE_W;

    logic [USED_W-1:0] slices;

    genvar g;
    generate
        for (g = 0; g < NUM_LANE; g++) begin : g_lane
            logic [LANE_W-1:0] sl;
            logic              hold_off;
            // Build one lane slice from its enable and code.
            always_comb begin
                hold_off             = !(stage_on && lane[g].en);
                sl                   = '0;
                sl[SL_OVR]           = 1'b0;
                sl[SL_CLSB +: CODE_W] = lane[g].en ? lane[g].code : '0;
                sl[SL_BYP]           = hold_off;
                sl[SL_PD]            = hold_off;
            end
            assign slices[g*LANE_W +: LANE_W] = sl;
        end
    endgenerate

    assign word = {{(WORD_W-USED_W){1'b0}}, slices};
endmodule

// File: rtl/rdly_seq_ctrl.sv
// Control FSM of the retune: IDLE -> OFF write -> ON write -> IDLE.
// Assumes wr_ready only while wr_valid, wr_fail only with wr_ready.
// Role check has priority over phase check; start ignored when busy.
module rdly_seq_ctrl
    import rdly_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic role_mac,
    input  logic phase_ok,
    input  logic wr_ready,
    input  logic wr_fail,
    output logic load,
    output logic wr_valid,
    output logic stage_on,
    output logic busy,
    output logic seq_done,
    output logic seq_skip,
    output logic err_phase,
    output logic err_bus
);
    seq_state_e state;

    // Capture strobe for the configuration registers.
    assign load     = (state == ST_IDLE) && start && !role_mac && phase_ok;
    assign wr_valid = (state != ST_IDLE);
    assign stage_on = (state == ST_ON);
    assign busy     = (state != ST_IDLE);

    // State transitions and one-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            seq_done  <= 1'b0;
            seq_skip  <= 1'b0;
            err_phase <= 1'b0;
            err_bus   <= 1'b0;
        end else begin
            seq_done  <= 1'b0;
            seq_skip  <= 1'b0;
            err_phase <= 1'b0;
            err_bus   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (role_mac)       seq_skip  <= 1'b1;
                        else if (!phase_ok) err_phase <= 1'b1;
                        else                state     <= ST_OFF;
                    end
                end
                ST_OFF: begin
                    if (wr_ready) begin
                        if (wr_fail) begin
                            err_bus <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            state   <= ST_ON;
                        end
                    end
                end
                ST_ON: begin
                    if (wr_ready) begin
                        if (wr_fail) err_bus  <= 1'b1;
                        else         seq_done <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6 R7 R9 R10: at most one outcome per cycle.
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_done, seq_skip, err_phase, err_bus}));

    // R8: the ON write only follows a clean acceptance of the OFF write.
    a_r8_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_on) |-> $past(wr_valid && wr_ready && !wr_fail));

    // R9: an aborted sequence presents no further write.
    a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_bus |-> !wr_valid);

    // R10: completion follows an accepted ON write and leaves the channel idle.
    a_r10_done_after_on: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!wr_valid && $past(stage_on && wr_ready)));

    // R8: the request is held until accepted.
    a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid);
endmodule

// File: rtl/rdly_retune_seq.sv
// Top of the delay-line retune sequencer for one port.
// Captures enables and delay code at start, then issues the OFF and ON
// pad delay words through a valid/ready write channel.
// Assumes the transport follows valid/ready with wr_fail qualified by wr_ready.
module rdly_retune_seq
    import rdly_pkg::*;
#(
    parameter int PHASE_W = 7,
    parameter int PH_MIN  = 74,
    parameter int PH_MAX  = 101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               role_mac,
    input  logic               rx_dly_en,
    input  logic               tx_dly_en,
    input  logic [PHASE_W-1:0] phase_deg,
    output logic               wr_valid,
    output logic [WORD_W-1:0]  wr_data,
    input  logic               wr_ready,
    input  logic               wr_fail,
    output logic               busy,
    output logic               seq_done,
    output logic               seq_skip,
    output logic               err_phase,
    output logic               err_bus
);
    localparam int CODE_MAX = (PH_MAX * 10 - 738) / 9;

    logic              phase_ok;
    logic [CODE_W-1:0] code_now;
    logic              load;
    logic              stage_on;
    logic              valid_int;
    lane_cfg_t         lane_q [NUM_LANE];
    logic [WORD_W-1:0] word;

    rdly_phase_code #(
        .PHASE_W (PHASE_W),
        .CODE_W  (CODE_W),
        .PH_MIN  (PH_MIN),
        .PH_MAX  (PH_MAX)
    ) u_code (
        .phase    (phase_deg),
        .in_range (phase_ok),
        .code     (code_now)
    );

    rdly_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .role_mac  (role_mac),
        .phase_ok  (phase_ok),
        .wr_ready  (wr_ready),
        .wr_fail   (wr_fail),
        .load      (load),
        .wr_valid  (valid_int),
        .stage_on  (stage_on),
        .busy      (busy),
        .seq_done  (seq_done),
        .seq_skip  (seq_skip),
        .err_phase (err_phase),
        .err_bus   (err_bus)
    );

    // Hold the lane configuration for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LANE; i++) lane_q[i] <= '0;
        end else if (load) begin
            lane_q[LANE_RX] <= '{en: rx_dly_en, code: code_now};
            lane_q[LANE_TX] <= '{en: tx_dly_en, code: code_now};
        end
    end

    rdly_word_pack u_pack (
        .lane     (lane_q),
        .stage_on (stage_on),
        .word     (word)
    );

    // Drive the channel; data is zero when nothing is requested.
    assign wr_valid = valid_int;
    assign wr_data  = valid_int ? word : '0;

    // R5: override bits never set.
    a_r5_no_override: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (!wr_data[15] && !wr_data[7]));

    // R3: the OFF write bypasses and powers down both lanes.
    a_r3_off_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !stage_on) |-> (wr_data[9:8] == 2'b11 && wr_data[1:0] == 2'b11));

    // R8: data stable while waiting for acceptance.
    a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> $stable(wr_data));

    // R6: skipped sequence issues no write.
    a_r6_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        seq_skip |-> !wr_valid);

    // R7: a range error issues no write.
    a_r7_range_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_phase |-> !wr_valid);

    // R1: captured code within the range the phase window allows.
    a_r1_code_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (int'(wr_data[14:10]) <= CODE_MAX && int'(wr_data[6:2]) <= CODE_MAX));

    // R11: configuration does not change while busy.
    a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lane_q[LANE_RX]));
endmodule

// File: tb/rdly_retune_seq_test.sv
module rdly_retune_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        role_mac = 1'b0;
    logic        rx_dly_en = 1'b0;
    logic        tx_dly_en = 1'b0;
    logic [6:0]  phase_deg = 7'd0;
    logic        wr_valid;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b0;
    logic        wr_fail = 1'b0;
    logic        busy, seq_done, seq_skip, err_phase, err_bus;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rdly_retune_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .role_mac(role_mac),
        .rx_dly_en(rx_dly_en), .tx_dly_en(tx_dly_en), .phase_deg(phase_deg),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .wr_fail(wr_fail), .busy(busy), .seq_done(seq_done),
        .seq_skip(seq_skip), .err_phase(err_phase), .err_bus(err_bus)
    );

    // Outcome codes: 0 none, 1 done, 2 skip, 3 phase error, 4 bus error.
    typedef struct packed {
        logic       mac;
        logic       rx;
        logic       tx;
        logic [6:0] ph;
        logic [1:0] lat;
        logic       f1;
        logic       f2;
        logic [2:0] oc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 7'd90,  2'd0, 1'b0, 1'b0, 3'd1},
        '{1'b0, 1'b1, 1'b0, 7'd90,  2'd1, 1'b0, 1'b0, 3'd1},
        '{1'b0, 1'b0, 1'b1, 7'd74,  2'd2, 1'b0, 1'b0, 3'd1},
        '{1'b0, 1'b0, 1'b0, 7'd101, 2'd0, 1'b0, 1'b0, 3'd1},
        '{1'b0, 1'b1, 1'b1, 7'd101, 2'd3, 1'b0, 1'b0, 3'd1},
        '{1'b1, 1'b1, 1'b1, 7'd90,  2'd0, 1'b0, 1'b0, 3'd2},
        '{1'b0, 1'b1, 1'b1, 7'd73,  2'd0, 1'b0, 1'b0, 3'd3},
        '{1'b0, 1'b1, 1'b1, 7'd102, 2'd0, 1'b0, 1'b0, 3'd3},
        '{1'b0, 1'b1, 1'b1, 7'd85,  2'd1, 1'b1, 1'b0, 3'd4},
        '{1'b0, 1'b1, 1'b0, 7'd95,  2'd0, 1'b0, 1'b1, 3'd4},
        '{1'b1, 1'b0, 1'b0, 7'd5,   2'd0, 1'b0, 1'b0, 3'd2},
        '{1'b0, 1'b0, 1'b1, 7'd80,  2'd2, 1'b0, 1'b0, 3'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1 code, R2 field layout, R3 first word, R4 second word.
    function automatic logic [31:0] exp_word(input bit rx, input bit tx, input int ph, input bit second);
        int code;
        logic [31:0] w;
        code = (ph * 10 - 738) / 9;
        w = '0;
        if (rx) w[14:10] = code[4:0];
        if (tx) w[6:2]   = code[4:0];
        w[9] = second ? !rx : 1'b1;
        w[8] = second ? !rx : 1'b1;
        w[1] = second ? !tx : 1'b1;
        w[0] = second ? !tx : 1'b1;
        return w;
    endfunction

    logic [31:0] got_w [2];
    int          got_n;
    int          got_oc;
    int          oc_iter;
    int          acc_iter;
    logic        valid_at_oc;

    // Issue one start and serve the write channel until an outcome shows.
    task automatic run_seq(input vec_t v, input bit poke);
        int wait_cnt;
        bit fin;
        got_n = 0; got_oc = 0; oc_iter = -1; acc_iter = -1; valid_at_oc = 1'b0;
        got_w[0] = '0; got_w[1] = '0;
        @(negedge clk);
        role_mac = v.mac; rx_dly_en = v.rx; tx_dly_en = v.tx;
        phase_deg = v.ph; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cnt = 0; fin = 0;
        for (int c = 0; c < 60 && !fin; c++) begin
            if (c > 0) @(negedge clk);
            wr_ready = 1'b0; wr_fail = 1'b0;
            start = 1'b0;
            if (seq_done || seq_skip || err_phase || err_bus) begin
                got_oc = seq_done ? 1 : seq_skip ? 2 : err_phase ? 3 : 4;
                oc_iter = c; valid_at_oc = wr_valid; fin = 1;
            end else if (wr_valid) begin
                if (poke && got_n == 0 && wait_cnt == 1) begin
                    // R11: conflicting start while busy.
                    start = 1'b1; role_mac = 1'b1;
                    rx_dly_en = !v.rx; tx_dly_en = !v.tx; phase_deg = 7'd100;
                end
                if (wait_cnt == int'(v.lat)) begin
                    wr_ready = 1'b1;
                    wr_fail  = (got_n == 0) ? v.f1 : v.f2;
                    if (got_n < 2) got_w[got_n] = wr_data;
                    got_n++; wait_cnt = 0; acc_iter = c;
                end else begin
                    wait_cnt++;
                end
            end
        end
        wr_ready = 1'b0; wr_fail = 1'b0; start = 1'b0;
    endtask

    task automatic judge(input vec_t v, input string tag);
        int exp_n;
        exp_n = (v.oc == 3'd2 || v.oc == 3'd3) ? 0 : (v.oc == 3'd4 && v.f1) ? 1 : 2;
        check({tag, " outcome R6 R7 R9 R10"}, got_oc, v.oc);
        check({tag, " write count R8 R9"}, got_n, exp_n);
        check({tag, " channel idle at outcome R9 R10"}, valid_at_oc, 1'b0);
        if (v.oc == 3'd2 || v.oc == 3'd3)
            check({tag, " pulse one cycle after start R6 R7"}, oc_iter, 0);
        else
            check({tag, " pulse one cycle after acceptance R10"}, oc_iter, acc_iter + 1);
        if (exp_n >= 1) begin
            check({tag, " first word R3"}, got_w[0], exp_word(v.rx, v.tx, v.ph, 1'b0));
            check({tag, " override clear R5"}, {31'd0, got_w[0][15] | got_w[0][7]}, 32'd0);
            if (v.rx)
                check({tag, " rx code R1"}, got_w[0][14:10], 32'((int'(v.ph) * 10 - 738) / 9));
        end
        if (exp_n == 2) begin
            check({tag, " second word R4"}, got_w[1], exp_word(v.rx, v.tx, v.ph, 1'b1));
            check({tag, " override clear R5"}, {31'd0, got_w[1][15] | got_w[1][7]}, 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state.
        check("R12 wr_valid", wr_valid, 0);
        check("R12 wr_data", wr_data, 0);
        check("R12 busy and pulses", {busy, seq_done, seq_skip, err_phase, err_bus}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_seq(VECS[i], 1'b0);
            judge(VECS[i], $sformatf("vec%0d", i));
        end

        // R11: start while busy ignored, captured settings kept.
        run_seq(VECS[4], 1'b1);
        judge(VECS[4], "busy-start R11");
        role_mac = 1'b0;

        // R12: reset in the middle of a sequence.
        @(negedge clk);
        rx_dly_en = 1'b1; tx_dly_en = 1'b1; phase_deg = 7'd90; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 request raised", wr_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 mid-sequence reset valid", wr_valid, 0);
        check("R12 mid-sequence reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 stays idle", {wr_valid, busy}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule